// File: doc/BRIEF.md
# Clock Divider Configuration Register Bank

This block holds the three divider settings of a clock synthesizer (input, feedback and output divider) behind a small memory-mapped bus. Each write lands in a shadow copy first. A write that carries a hold flag stays in the shadow only. A write with the hold flag clear copies every shadow into the active set in one step, so software can stage two dividers and then commit the whole set atomically with the third.

Each commit starts a settling sequence. The lock indication falls at once and rises again after a parameterised number of clock cycles. A fresh commit during settling restarts the count. The error indication is evaluated on every commit. It is set when any committed divider decodes to a ratio of zero, where a divider's ratio is 1 in bypass and otherwise the sum of its high and low counts. The active words drive the clock synthesizer outside this block, and lock and error are both visible as outputs and in a status word.

Top module: `clkgen_cfg_regs`

## Requirements
- R1: Address map: 0x0 input divider, 0x4 feedback divider, 0x8 output divider, 0xC status. Divider word layout: low count in bits 5:0, high count in bits 11:6, odd-edge flag in bit 12, bypass in bit 13, hold (no-update) in bit 14, and bits 31:15 reserved.
- R2: A read of a divider offset returns its shadow word, which is the last value written to it, with bits 31:15 zero.
- R3: A divider write with bit 14 set changes only that shadow word. All three active outputs stay unchanged.
- R4: A divider write with bit 14 clear commits. On that clock edge the written word and the other two shadow words become the active words.
- R5: On the commit edge the lock output falls. It rises exactly SETTLE_CYCLES clock edges after the latest commit, so a commit during settling restarts the count.
- R6: At each commit the error output is set if any committed word has a ratio of zero, and cleared otherwise. The ratio is 1 when bypass is set and high+low when it is not.
- R7: A status read returns lock in bit 0 and error in bit 1, with all other bits zero.
- R8: Writes to undefined offsets and to the status offset have no effect. Reads from undefined offsets return zero.
- R9: After reset every shadow and active word is 0x2000 (bypass), lock is 1 and error is 0.
- R10: Bits 31:15 of each active output are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| in_div_word | output | DATA_W | Active input divider word |
| fb_div_word | output | DATA_W | Active feedback divider word |
| out_div_word | output | DATA_W | Active output divider word |
| pll_locked | output | 1 | Lock indication |
| pll_error | output | 1 | Invalid-setting indication |

## Verification
The bench builds the block with SETTLE_CYCLES set to 4 instead of the microsecond-scale default. This keeps the fall and rise of lock, and a commit that restarts settling, within a few cycles of each other, so each edge of the lock window can be sampled exactly. The address width stays at its default, which leaves spare offsets inside the 4-bit space for the ignored-write and zero-read cases.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int WORD_W     = 15;
    localparam int NUM_DIV    = 3;
    localparam int OFF_STEP   = 4;
    localparam int OFF_STATUS = 12;

    // Stored divider word; field order matches the bus bit positions
    typedef struct packed {
        logic       hold;
        logic       bypass;
        logic       odd_edge;
        logic [5:0] high_cnt;
        logic [5:0] low_cnt;
    } div_word_t;

    localparam div_word_t RESET_WORD = '{
        hold: 1'b0, bypass: 1'b1, odd_edge: 1'b0,
        high_cnt: 6'd0, low_cnt: 6'd0
    };

    function automatic logic [6:0] div_ratio(div_word_t w);
        return w.bypass ? 7'd1 : ({1'b0, w.high_cnt} + {1'b0, w.low_cnt});
    endfunction

    function automatic int div_offset(int idx);
        return idx * OFF_STEP;
    endfunction

endpackage

// File: rtl/clkgen_div_slot.sv
module clkgen_div_slot
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_sel,
    input  logic      commit,
    input  div_word_t wr_word,
    output div_word_t shadow_o,
    output div_word_t next_o,
    output div_word_t active_o
);
    div_word_t shadow_q;
    div_word_t active_q;

    // value this slot would commit on the current edge
    assign next_o = wr_sel ? wr_word : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RESET_WORD;
            active_q <= RESET_WORD;
        end else begin
            if (wr_sel) shadow_q <= wr_word;
            if (commit) active_q <= next_o;
        end
    end

    assign shadow_o = shadow_q;
    assign active_o = active_q;
endmodule

// File: rtl/clkgen_lock_timer.sv
module clkgen_lock_timer #(
    parameter int SETTLE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic bad_cfg,
    output logic locked,
    output logic cfg_err
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (commit) begin
            lock_q <= 1'b0;
            cnt_q  <= CNT_W'(SETTLE_CYCLES - 1);
            err_q  <= bad_cfg;
        end else if (!lock_q) begin
            if (cnt_q == '0) lock_q <= 1'b1;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign locked  = lock_q;
    assign cfg_err = err_q;
endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
    import clkgen_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 32,
    parameter int SETTLE_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] in_div_word,
    output logic [DATA_W-1:0] fb_div_word,
    output logic [DATA_W-1:0] out_div_word,
    output logic              pll_locked,
    output logic              pll_error
);
    localparam int PAD_W = DATA_W - WORD_W;

    div_word_t            wr_word;
    div_word_t            shadow_w [NUM_DIV];
    div_word_t            next_w   [NUM_DIV];
    div_word_t            active_w [NUM_DIV];
    logic [NUM_DIV-1:0]   wr_sel;
    logic [NUM_DIV-1:0]   zero_ratio;
    logic                 commit;
    logic                 bad_cfg;
    logic                 unused_hi;

    assign wr_word   = div_word_t'(bus_wdata[WORD_W-1:0]);
    assign unused_hi = ^bus_wdata[DATA_W-1:WORD_W];

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_slot
        assign wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(div_offset(i)));

        clkgen_div_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_sel[i]),
            .commit   (commit),
            .wr_word  (wr_word),
            .shadow_o (shadow_w[i]),
            .next_o   (next_w[i]),
            .active_o (active_w[i])
        );

        assign zero_ratio[i] = (div_ratio(next_w[i]) == 7'd0);
    end

    assign commit  = (|wr_sel) && !wr_word.hold;
    assign bad_cfg = |zero_ratio;

    clkgen_lock_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .bad_cfg (bad_cfg),
        .locked  (pll_locked),
        .cfg_err (pll_error)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (bus_addr == ADDR_W'(div_offset(i)))
                bus_rdata = {{PAD_W{1'b0}}, shadow_w[i]};
        end
        if (bus_addr == ADDR_W'(OFF_STATUS))
            bus_rdata[1:0] = {pll_error, pll_locked};
    end

    assign in_div_word  = {{PAD_W{1'b0}}, active_w[0]};
    assign fb_div_word  = {{PAD_W{1'b0}}, active_w[1]};
    assign out_div_word = {{PAD_W{1'b0}}, active_w[2]};
endmodule

// File: rtl/clkgen_cfg_chk.sv
module clkgen_cfg_chk
    import clkgen_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] in_div_word,
    input logic [DATA_W-1:0] fb_div_word,
    input logic [DATA_W-1:0] out_div_word,
    input logic              pll_locked,
    input logic              pll_error
);
    logic addr_div;
    logic addr_known;
    logic do_commit;
    logic act_zero;

    assign addr_div   = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(4))
                     || (bus_addr == ADDR_W'(8));
    assign addr_known = addr_div || (bus_addr == ADDR_W'(12));
    assign do_commit  = bus_wr && addr_div && !bus_wdata[14];
    assign act_zero   = (div_ratio(div_word_t'(in_div_word[WORD_W-1:0]))  == 7'd0)
                     || (div_ratio(div_word_t'(fb_div_word[WORD_W-1:0]))  == 7'd0)
                     || (div_ratio(div_word_t'(out_div_word[WORD_W-1:0])) == 7'd0);

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
        do_commit |=> !pll_locked); // R5

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        !do_commit |=> ($stable(in_div_word) && $stable(fb_div_word)
                        && $stable(out_div_word))); // R3

    AST_ERR_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        pll_error == act_zero); // R6

    AST_ACTIVE_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_div_word[DATA_W-1:WORD_W] == '0) && (fb_div_word[DATA_W-1:WORD_W] == '0)
        && (out_div_word[DATA_W-1:WORD_W] == '0)); // R10

    AST_READ_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        addr_div |-> (bus_rdata[DATA_W-1:WORD_W] == '0)); // R2

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !addr_known |-> (bus_rdata == '0)); // R8
endmodule

bind clkgen_cfg_regs clkgen_cfg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .in_div_word  (in_div_word),
    .fb_div_word  (fb_div_word),
    .out_div_word (out_div_word),
    .pll_locked   (pll_locked),
    .pll_error    (pll_error)
);

// File: tb/test_clkgen_cfg_regs.sv
module test_clkgen_cfg_regs;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, in_w, fb_w, out_w;
    logic        locked, err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clkgen_cfg_regs #(.ADDR_W(4), .DATA_W(32), .SETTLE_CYCLES(SETTLE)) i_clkgen_cfg_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_div_word(in_w),
        .fb_div_word(fb_w), .out_div_word(out_w), .pll_locked(locked),
        .pll_error(err)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] ein;
        logic [31:0] efb;
        logic [31:0] eout;
        logic [31:0] erd;
    } vec_t;

    // encodings: div 2 = 0x041, div 30 = 0x3CF, div 20 = 0x28A, hold = bit 14
    localparam vec_t VECS [6] = '{
        '{4'h0, 32'h0000_4041, 32'h2000, 32'h2000, 32'h2000, 32'h4041},
        '{4'h4, 32'h0000_43CF, 32'h2000, 32'h2000, 32'h2000, 32'h43CF},
        '{4'h8, 32'h0000_028A, 32'h4041, 32'h43CF, 32'h028A, 32'h028A},
        '{4'h0, 32'hABCD_4042, 32'h4041, 32'h43CF, 32'h028A, 32'h4042},
        '{4'h2, 32'h0000_0001, 32'h4041, 32'h43CF, 32'h028A, 32'h0000},
        '{4'h4, 32'h0000_0000, 32'h4042, 32'h0000, 32'h028A, 32'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check("R9 in", in_w, 32'h2000);
        check("R9 fb", fb_w, 32'h2000);
        check("R9 out", out_w, 32'h2000);
        rd(4'h8, r); check("R9 shadow out", r, 32'h2000);
        rd(4'hC, r); check("R9 R7 status", r, 32'h1);

        // R1 R2 R3 R4 R8 vector walk
        for (int i = 0; i < 6; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            check("R3 R4 in", in_w, VECS[i].ein);
            check("R3 R4 fb", fb_w, VECS[i].efb);
            check("R3 R4 out", out_w, VECS[i].eout);
            rd(VECS[i].addr, r); check("R2 R8 readback", r, VECS[i].erd);
        end

        // R6 zero feedback ratio committed; R7 status = err, not locked
        rd(4'hC, r); check("R6 R7 error set", r, 32'h2);

        // R6 valid commit clears error; R5 lock window
        wr(4'h4, 32'h0000_03CF);
        rd(4'hC, r); check("R6 error cleared", r, 32'h0);
        repeat (SETTLE - 1) @(negedge clk);
        check("R5 still unlocked", {31'd0, locked}, 32'h0);
        @(negedge clk);
        check("R5 locked", {31'd0, locked}, 32'h1);

        // R8 status write ignored
        wr(4'hC, 32'h0000_0002);
        rd(4'hC, r); check("R8 status write ignored", r, 32'h1);
        check("R8 actives held", fb_w, 32'h03CF);

        // R6 bypass with zero counts is valid, without bypass invalid
        wr(4'h8, 32'h0000_2000);
        check("R6 bypass ok", {31'd0, err}, 32'h0);
        check("R4 out bypass", out_w, 32'h2000);
        wr(4'h8, 32'h0000_0000);
        check("R6 zero out", {31'd0, err}, 32'h1);
        wr(4'h8, 32'h0000_0041);
        check("R6 recovered", {31'd0, err}, 32'h0);

        // R5 commit during settling restarts the count
        repeat (SETTLE + 1) @(negedge clk);
        wr(4'h0, 32'h0000_0041);
        repeat (2) @(negedge clk);
        wr(4'h0, 32'h0000_0042);
        check("R5 dropped on restart", {31'd0, locked}, 32'h0);
        repeat (SETTLE - 1) @(negedge clk);
        check("R5 restart holds low", {31'd0, locked}, 32'h0);
        @(negedge clk);
        check("R5 restart locks", {31'd0, locked}, 32'h1);
        check("R4 in after restart", in_w, 32'h0042);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule